// File: doc/BRIEF.md
# I2C Address Presence Scanner

This block walks through all 128 seven-bit I2C address values, in ascending order starting from zero, and finds out which of them a device answers. It does no bit-level signalling itself. It drives a byte-level command channel into a separate bus master, which performs a START, a byte send, a byte receive answered with NACK, or a STOP. That master returns a completion pulse and, for a sent byte, the acknowledge bit it saw. The result is a 128-bit presence map. Bit n of the map is set when address n answered.

The scan only probes addresses 0x07 through 0x77. Every other address is stepped over without any bus traffic and left marked absent. Each probe works like this:
- The block issues a START. The bus master turns every START after the first into a repeated START, because no STOP comes between probes.
- It sends the address shifted left by one with the read bit set.
- If that byte is acknowledged, it receives one byte, answers it with NACK, and throws the byte away. This returns the bus to the controller before the next START.

A single STOP closes the whole scan after address 0x7F has been passed. A one-cycle start pulse launches a scan. A busy level covers the whole scan, and a one-cycle done pulse marks its end.

The controller has twelve states:
- IDLE waits for a start pulse. On the pulse it clears the map, resets the address walker and goes to SELECT.
- SELECT tests the current address. An address in range goes to START_REQ. An address out of range steps forward and stays in SELECT. If the out-of-range address is the last one (0x7F), it goes to STOP_REQ.
- START_REQ goes to START_WAIT. START_WAIT goes to ADDR_REQ on completion.
- ADDR_REQ goes to ADDR_WAIT. On completion, ADDR_WAIT records the acknowledge and goes to READ_REQ if acknowledged, or to ADVANCE if not.
- READ_REQ goes to READ_WAIT. READ_WAIT goes to ADVANCE on completion.
- ADVANCE steps to the next address and goes to SELECT. At the last address it goes to STOP_REQ instead.
- STOP_REQ goes to STOP_WAIT. STOP_WAIT goes to FINISH on completion.
- FINISH pulses done and returns to IDLE.

Top module: `i2c_probe_scanner`

## Requirements
- R1: A `scan_start` pulse seen while idle raises `scan_busy` on the next cycle and clears `present_map` to all zeros in that same cycle.
- R2: Addresses below 0x07 and above 0x77 are never sent on the command channel, and their map bits stay 0 even if a device would answer there.
- R3: Each probe is a START command (`cmd_op` = 1) followed by a byte-send command (`cmd_op` = 2) whose `cmd_data` is the 7-bit address in bits 7:1 with bit 0 = 1 (read).
- R4: Map bit n, where n is the 7-bit address, is 1 exactly when `cmd_ack` was 1 with the `cmd_done` of that address byte. It is 0 otherwise.
- R5: After an acknowledged address byte, exactly one receive-with-NACK command (`cmd_op` = 3) is issued before the next START or the STOP. After an unacknowledged one, none is issued.
- R6: Every address from 0x07 to 0x77 is probed exactly once, in strictly ascending order.
- R7: Exactly one STOP command (`cmd_op` = 4) is issued per scan, and it is the last command of the scan.
- R8: `cmd_valid` is a one-cycle pulse. No new command is issued until `cmd_done` has answered the previous one.
- R9: `scan_done` is high for exactly one cycle, in the cycle after the STOP's `cmd_done`. `scan_busy` is low in that cycle and stays low afterwards.
- R10: A `scan_start` pulse during a scan is ignored. The running scan's commands and result are unchanged.
- R11: While idle, with no start pulse, `present_map` holds its value and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | One-cycle pulse that begins a scan |
| scan_busy | output | 1 | High while a scan is in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| present_map | output | 128 | Presence bit for each 7-bit address |
| cmd_valid | output | 1 | One-cycle command request to the bus master |
| cmd_op | output | 3 | Command: 1 START, 2 send byte, 3 receive byte with NACK, 4 STOP |
| cmd_data | output | 8 | Byte to send for command 2 |
| cmd_done | input | 1 | Completion pulse from the bus master |
| cmd_ack | input | 1 | Acknowledge seen on the sent byte, valid with cmd_done |

## Verification
The hardest case to reach is a scan where the skip logic and the acknowledge logic meet at the edges of the range:
- a responder at 0x07 and at 0x77 must be found;
- responders at 0x00, 0x03, 0x78 and 0x7F must produce no traffic at all;
- the STOP must still follow the final skipped address.

The bench reaches this case with a behavioural responder that holds a programmable device set, which includes those reserved addresses, and that answers after a latency it can vary. The responder also checks the ordering of every command it receives. A start pulse injected in the middle of another scan covers the ignored-restart case.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_START     = 3'd1,
        OP_SEND      = 3'd2,
        OP_RECV_NACK = 3'd3,
        OP_STOP      = 3'd4
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SELECT,
        S_START_REQ,
        S_START_WAIT,
        S_ADDR_REQ,
        S_ADDR_WAIT,
        S_READ_REQ,
        S_READ_WAIT,
        S_ADVANCE,
        S_STOP_REQ,
        S_STOP_WAIT,
        S_FINISH
    } scan_state_e;
endpackage

// File: rtl/scan_addr_walker.sv
module scan_addr_walker #(
    parameter int ADDR_W = 7,
    parameter int FIRST  = 7,
    parameter int LAST   = 119
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic              is_last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (clear) addr <= '0;
        else if (step)  addr <= addr + 1'b1;
    end

    always_comb begin
        in_range = (int'(addr) >= FIRST) && (int'(addr) <= LAST);
        is_last  = (addr == TOP);
    end
endmodule

// File: rtl/scan_map_reg.sv
module scan_map_reg #(
    parameter int ADDR_W = 7,
    localparam int MAP_W = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic              wr_val,
    output logic [MAP_W-1:0]  map
);
    for (genvar g = 0; g < MAP_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   map[g] <= 1'b0;
            else if (clear)                               map[g] <= 1'b0;
            else if (wr_en && (wr_idx == ADDR_W'(g)))     map[g] <= wr_val;
        end
    end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_range,
    input  logic              is_last,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    output logic              walk_clear,
    output logic              walk_step,
    output logic              map_clear,
    output logic              map_wr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_data,
    output logic              busy,
    output logic              done
);
    scan_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start) state_nx = S_SELECT;
            S_SELECT:     if (in_range)     state_nx = S_START_REQ;
                          else if (is_last) state_nx = S_STOP_REQ;
            S_START_REQ:  state_nx = S_START_WAIT;
            S_START_WAIT: if (cmd_done) state_nx = S_ADDR_REQ;
            S_ADDR_REQ:   state_nx = S_ADDR_WAIT;
            S_ADDR_WAIT:  if (cmd_done) state_nx = cmd_ack ? S_READ_REQ : S_ADVANCE;
            S_READ_REQ:   state_nx = S_READ_WAIT;
            S_READ_WAIT:  if (cmd_done) state_nx = S_ADVANCE;
            S_ADVANCE:    state_nx = is_last ? S_STOP_REQ : S_SELECT;
            S_STOP_REQ:   state_nx = S_STOP_WAIT;
            S_STOP_WAIT:  if (cmd_done) state_nx = S_FINISH;
            S_FINISH:     state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        walk_clear = 1'b0;
        walk_step  = 1'b0;
        map_clear  = 1'b0;
        map_wr     = 1'b0;
        cmd_valid  = 1'b0;
        cmd_op     = OP_NONE;
        cmd_data   = {addr, 1'b1};
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy       = 1'b0;
                walk_clear = start;
                map_clear  = start;
            end
            S_SELECT:     walk_step = !in_range && !is_last;
            S_START_REQ:  begin cmd_valid = 1'b1; cmd_op = OP_START;     end
            S_ADDR_REQ:   begin cmd_valid = 1'b1; cmd_op = OP_SEND;      end
            S_ADDR_WAIT:  map_wr = cmd_done;
            S_READ_REQ:   begin cmd_valid = 1'b1; cmd_op = OP_RECV_NACK; end
            S_ADVANCE:    walk_step = !is_last;
            S_STOP_REQ:   begin cmd_valid = 1'b1; cmd_op = OP_STOP;      end
            S_FINISH:     begin busy = 1'b0; done = 1'b1;                end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_probe_scanner.sv
module i2c_probe_scanner #(
    parameter int ADDR_W = 7,
    parameter int FIRST  = 7,
    parameter int LAST   = 119,
    localparam int MAP_W = 1 << ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_start,
    output logic             scan_busy,
    output logic             scan_done,
    output logic [MAP_W-1:0] present_map,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_data,
    input  logic             cmd_done,
    input  logic             cmd_ack
);
    logic [ADDR_W-1:0] addr;
    logic in_range, is_last, walk_clear, walk_step, map_clear, map_wr;

    scan_addr_walker #(.ADDR_W(ADDR_W), .FIRST(FIRST), .LAST(LAST)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(walk_clear), .step(walk_step),
        .addr(addr), .in_range(in_range), .is_last(is_last)
    );

    scan_map_reg #(.ADDR_W(ADDR_W)) u_map (
        .clk(clk), .rst_n(rst_n), .clear(map_clear), .wr_en(map_wr),
        .wr_idx(addr), .wr_val(cmd_ack), .map(present_map)
    );

    scan_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(scan_start),
        .in_range(in_range), .is_last(is_last), .addr(addr),
        .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .walk_clear(walk_clear), .walk_step(walk_step),
        .map_clear(map_clear), .map_wr(map_wr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .busy(scan_busy), .done(scan_done)
    );
endmodule

// File: rtl/scan_checks.sv
module scan_checks #(
    parameter int ADDR_W = 7,
    parameter int FIRST  = 7,
    parameter int LAST   = 119,
    localparam int MAP_W = 1 << ADDR_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_start,
    input logic             scan_busy,
    input logic             scan_done,
    input logic [MAP_W-1:0] present_map,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [7:0]       cmd_data,
    input logic             cmd_done
);
    logic pend;
    logic reserved_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend <= 1'b0;
        else if (cmd_valid) pend <= 1'b1;
        else if (cmd_done)  pend <= 1'b0;
    end

    always_comb begin
        reserved_clear = 1'b1;
        for (int i = 0; i < MAP_W; i++)
            if ((i < FIRST || i > LAST) && present_map[i]) reserved_clear = 1'b0;
    end

    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_start && !scan_busy) |=> (scan_busy && present_map == '0));

    p_reserved_absent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_clear);

    p_read_bit_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |-> cmd_data[0]);

    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !pend);

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !scan_busy);

    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_busy) |-> scan_done);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy && !scan_start) |=> ($stable(present_map) && !cmd_valid));
endmodule

bind i2c_probe_scanner scan_checks #(.ADDR_W(ADDR_W), .FIRST(FIRST), .LAST(LAST)) u_scan_checks (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_busy(scan_busy),
    .scan_done(scan_done), .present_map(present_map), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_done(cmd_done)
);

// File: tb/test_i2c_probe_scanner.sv
`timescale 1ns/1ps
module test_i2c_probe_scanner;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_start = 1'b0;
    logic         scan_busy, scan_done;
    logic [127:0] present_map;
    logic         cmd_valid;
    logic [2:0]   cmd_op;
    logic [7:0]   cmd_data;
    logic         cmd_done, cmd_ack;

    i2c_probe_scanner i_i2c_probe_scanner (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
        .scan_busy(scan_busy), .scan_done(scan_done), .present_map(present_map),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_done(cmd_done), .cmd_ack(cmd_ack)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // responder state and log
    logic [127:0] dev_set = '0;
    logic [127:0] probed;
    int  resp_lat = 1;
    int  n_start, n_send, n_recv, n_stop, n_after_stop, seq_err, order_err;
    int  prev_addr, stop_done_cyc;
    int  expect_next; // 0 any start/stop, 1 send, 2 recv
    logic [127:0] range_mask;

    initial begin
        range_mask = '0;
        for (int i = 7; i <= 119; i++) range_mask[i] = 1'b1;
    end

    task automatic clear_log();
        probed = '0; n_start = 0; n_send = 0; n_recv = 0; n_stop = 0;
        n_after_stop = 0; seq_err = 0; order_err = 0; prev_addr = -1;
        stop_done_cyc = -10; expect_next = 0;
    endtask

    initial begin
        logic a;
        cmd_done = 1'b0; cmd_ack = 1'b0;
        clear_log();
        forever begin
            if (cmd_valid === 1'b1) begin
                a = 1'b0;
                if (n_stop != 0) n_after_stop++;
                case (cmd_op)
                    3'd1: begin n_start++; if (expect_next != 0) seq_err++; expect_next = 1; end
                    3'd2: begin
                        n_send++;
                        if (expect_next != 1 || cmd_data[0] != 1'b1) seq_err++;
                        if (int'(cmd_data[7:1]) <= prev_addr) order_err++;
                        prev_addr = int'(cmd_data[7:1]);
                        if (probed[cmd_data[7:1]]) order_err++;
                        probed[cmd_data[7:1]] = 1'b1;
                        a = dev_set[cmd_data[7:1]] & cmd_data[0];
                        expect_next = a ? 2 : 0;
                    end
                    3'd3: begin n_recv++; if (expect_next != 2) seq_err++; expect_next = 0; end
                    3'd4: begin n_stop++; if (expect_next != 0) seq_err++; end
                    default: seq_err++;
                endcase
                repeat (resp_lat) @(negedge clk);
                cmd_done = 1'b1; cmd_ack = a;
                if (cmd_op == 3'd4 || n_stop != 0) stop_done_cyc = cyc;
                @(negedge clk);
                cmd_done = 1'b0; cmd_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
    endtask

    // waits for done at negedges; returns cycle seen
    task automatic wait_done(output int seen, output bit ok);
        ok = 1'b0; seen = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (scan_done) begin ok = 1'b1; seen = cyc; break; end
        end
    endtask

    task automatic run_and_check(input string name, input bit mid_start, input logic [127:0] exp_map_in);
        int seen; bit ok; int exp_recv;
        logic [127:0] exp_map;
        exp_map = exp_map_in & range_mask;
        exp_recv = $countones(exp_map);
        clear_log();
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
        check(scan_busy === 1'b1, "R1 busy after start", 128'(scan_busy), 1);
        check(present_map === '0, "R1 map cleared", present_map, 0);
        if (mid_start) begin
            repeat (300) @(negedge clk);
            scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
        end
        wait_done(seen, ok);
        if (!ok) begin
            check(1'b0, {"watchdog ", name}, 0, 1);
            return;
        end
        check(scan_busy === 1'b0, "R9 busy low with done", 128'(scan_busy), 0);
        check(seen == stop_done_cyc + 1, "R9 done one cycle after stop completion", 128'(seen), 128'(stop_done_cyc + 1));
        check(present_map === exp_map, "R4 presence map", present_map, exp_map);
        check(probed === range_mask, "R2/R6 probed set R2 R6", probed, range_mask);
        check(n_start == 113 && n_send == 113, "R3 probe count", 128'(n_start), 113);
        check(n_recv == exp_recv, "R5 receive count", 128'(n_recv), 128'(exp_recv));
        check(seq_err == 0, "R5 command ordering", 128'(seq_err), 0);
        check(order_err == 0, "R6 ascending order", 128'(order_err), 0);
        check(n_stop == 1 && n_after_stop == 0, "R7 single final stop", 128'(n_stop), 1);
        @(negedge clk);
        check(scan_done === 1'b0, "R9 done width", 128'(scan_done), 0);
        if (mid_start)
            check(n_start == 113 && present_map === exp_map, "R10 restart ignored", 128'(n_start), 113);
        repeat (20) @(negedge clk);
        check(present_map === exp_map && n_send == 113, "R11 idle stable", present_map, exp_map);
    endtask

    task automatic t_reset();
        check(scan_busy === 1'b0 && scan_done === 1'b0, "R9 reset busy/done", 128'({scan_busy, scan_done}), 0);
        check(present_map === '0, "R11 reset map", present_map, 0);
        check(cmd_valid === 1'b0, "R8 reset cmd_valid", 128'(cmd_valid), 0);
    endtask

    task automatic t_single();
        dev_set = '0; dev_set[8'h68] = 1'b1; resp_lat = 2;
        run_and_check("single", 1'b0, dev_set);
    endtask

    task automatic t_edges();
        dev_set = '0;
        dev_set[7] = 1; dev_set[119] = 1; dev_set[0] = 1; dev_set[3] = 1;
        dev_set[120] = 1; dev_set[127] = 1;
        resp_lat = 1;
        run_and_check("edges R2", 1'b0, dev_set);
    endtask

    task automatic t_many_restart();
        dev_set = '0;
        for (int i = 0; i < 128; i += 5) dev_set[i] = 1'b1;
        resp_lat = 4;
        run_and_check("many R10", 1'b1, dev_set);
    endtask

    task automatic t_none();
        dev_set = '0; resp_lat = 3;
        run_and_check("none", 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_single();
        t_edges();
        t_many_restart();
        t_none();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule